// File: doc/BRIEF.md
# Four-Strike Watchdog Timer

This block is a bus-programmed watchdog built around a prescaling tick timer. The tick timer counts pulses of a fixed 1 MHz reference enable and emits one tick every programmed number of reference pulses. The watchdog counts those ticks down from an 8-bit period. Each time the count runs out, it bumps a 2-bit expiry tally and reloads. On the fourth run-out, and only when reset generation is enabled, it raises a one-cycle system reset request and falls back to the idle state.

Software drives everything through a 32-bit write/read register port with a word address. A start command arms the count. Repeating that command while the count is live is the keep-alive: it reloads the count and forgets earlier expiries. Stopping the watchdog is guarded. A stop command only takes effect if the write just before it on the command path was a correct key written to the key register. An optional interrupt flag reports the first expiry and holds until software restarts or stops the count.

Top module: `wdg_unit`

## Requirements
- R1: After reset every register reads 0, `irq_o` and `sys_rst_req_o` are low, and no counting takes place.
- R2: The timer register at offset 0x10 holds a reload value N in bits [28:0], a periodic flag in bit 30 and an enable flag in bit 31, and it reads back as written. With the enable flag set, the timer emits one tick per N+1 pulses of `ref_tick_i`.
- R3: With the periodic flag clear, the timer emits a single tick and then clears its enable flag, which reads back as 0. Writing 0 to the timer register stops all ticks.
- R4: The config register at offset 0x0 holds a timer select in [3:0], the period in [11:4], an interrupt enable in bit 12 and a reset enable in bit 15. All other bits read as 0.
- R5: Writing bit 0 to the command register at offset 0x8 loads the countdown from the period and clears the expiry tally. A period of 0 is treated as 1. The status register at offset 0x4 shows the countdown in [11:4] and the tally in [13:12].
- R6: Each tick decrements the live countdown. A tick that would bring it to zero instead reloads it from the period and adds one to the tally.
- R7: A start command while the count is live reloads the countdown, clears the tally and clears the interrupt flag.
- R8: When reset enable is set, the fourth expiry raises `sys_rst_req_o` for exactly one cycle. The countdown then stops, and status reads 0.
- R9: When reset enable is clear, no reset request is made. The tally saturates at 3 and counting continues.
- R10: A command write with bit 1 set stops the count and clears countdown and tally. It does so only if the most recent write to the key register at offset 0xC was exactly 0x0000C45A and no other command write came in between. Otherwise the stop is ignored. A wrong key disarms.
- R11: With interrupt enable set, `irq_o` rises at the first expiry and stays high until a start or a stop command. With interrupt enable clear it never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle enable pulse at the 1 MHz reference rate |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Expiry interrupt flag |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A register write lands on the clock edge that samples the strobe, so its effect shows on `rdata_o` before the next edge. A reference pulse sampled at one edge produces a registered tick. The countdown, the interrupt flag and the reset request then change on the following edge, two edges after the pulse. The bench drives every input just after a falling edge and sends each reference pulse as a single-cycle pulse. It reads the status, `irq_o` and `sys_rst_req_o` only after the falling edge that follows that second rising edge, and looks again one cycle later to confirm that the reset request has dropped.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int DATA_W      = 32;
    localparam int SEL_W       = 4;
    localparam int PER_LSB     = 4;
    localparam int PER_W       = 8;
    localparam int IRQ_EN_BIT  = 12;
    localparam int RST_EN_BIT  = 15;
    localparam int EXP_LSB     = 12;
    localparam int EXP_W       = 2;
    localparam int TMR_EN_BIT  = 31;
    localparam int TMR_PER_BIT = 30;
    localparam int CMD_GO_BIT  = 0;
    localparam int CMD_HALT_BIT = 1;

    typedef enum logic [2:0] {
        SLOT_CFG = 3'd0,
        SLOT_STS = 3'd1,
        SLOT_CMD = 3'd2,
        SLOT_KEY = 3'd3,
        SLOT_TMR = 3'd4
    } reg_slot_e;
endpackage

// File: rtl/wdg_bus_decode.sv
module wdg_bus_decode
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 5,
    localparam int WA_W  = ADDR_W - 2
) (
    input  logic              wr_en,
    input  logic [WA_W-1:0]   word_addr,
    input  logic [DATA_W-1:0] cfg_rd,
    input  logic [DATA_W-1:0] sts_rd,
    input  logic [DATA_W-1:0] tmr_rd,
    output logic              cfg_wr,
    output logic              cmd_wr,
    output logic              key_wr,
    output logic              tmr_wr,
    output logic [DATA_W-1:0] rdata
);
    reg_slot_e slot;
    logic      in_range;

    always_comb begin
        slot     = reg_slot_e'(word_addr[2:0]);
        in_range = (word_addr >> 3) == '0;
        cfg_wr   = 1'b0;
        cmd_wr   = 1'b0;
        key_wr   = 1'b0;
        tmr_wr   = 1'b0;
        rdata    = '0;
        if (in_range) begin
            case (slot)
                SLOT_CFG: begin cfg_wr = wr_en; rdata = cfg_rd; end
                SLOT_STS: rdata = sts_rd;
                SLOT_CMD: cmd_wr = wr_en;
                SLOT_KEY: key_wr = wr_en;
                SLOT_TMR: begin tmr_wr = wr_en; rdata = tmr_rd; end
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdg_tick_timer.sv
module wdg_tick_timer
    import wdg_pkg::*;
#(
    parameter int RELOAD_W = 29,
    localparam int IN_W    = RELOAD_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_pulse,
    input  logic              wr,
    input  logic [IN_W-1:0]   wdata,
    output logic              tick,
    output logic [DATA_W-1:0] rd
);
    typedef struct packed {
        logic                en;
        logic                periodic;
        logic [RELOAD_W-1:0] reload;
        logic [RELOAD_W-1:0] cnt;
        logic                tick;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (wr) begin
            st_d.en       = wdata[IN_W-1];
            st_d.periodic = wdata[IN_W-2];
            st_d.reload   = wdata[RELOAD_W-1:0];
            st_d.cnt      = '0;
        end else if (st_q.en && ref_pulse) begin
            if (st_q.cnt == st_q.reload) begin
                st_d.tick = 1'b1;
                st_d.cnt  = '0;
                if (!st_q.periodic) st_d.en = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd                 = '0;
        rd[RELOAD_W-1:0]   = st_q.reload;
        rd[TMR_PER_BIT]    = st_q.periodic;
        rd[TMR_EN_BIT]     = st_q.en;
    end

    assign tick = st_q.tick;

    p_tick_from_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |-> $past(ref_pulse));

    p_oneshot_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tick && !st_q.periodic) |-> !st_q.en);
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown
    import wdg_pkg::*;
#(
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_C45A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cmd_wr,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    output logic [DATA_W-1:0] cfg_rd,
    output logic [DATA_W-1:0] sts_rd,
    output logic              irq,
    output logic              rst_req
);
    localparam logic [EXP_W-1:0] EXP_LAST = '1;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [PER_W-1:0] period;
        logic             irq_en;
        logic             rst_en;
        logic             running;
        logic [PER_W-1:0] cnt;
        logic [EXP_W-1:0] expn;
        logic             irq;
        logic             armed;
        logic             rst;
    } wd_st_t;

    wd_st_t           st_d, st_q;
    logic [PER_W-1:0] eff_period;

    always_comb begin
        eff_period = (st_q.period == '0) ? PER_W'(1) : st_q.period;
        st_d       = st_q;
        st_d.rst   = 1'b0;

        if (cfg_wr) begin
            st_d.sel    = wdata[SEL_W-1:0];
            st_d.period = wdata[PER_LSB +: PER_W];
            st_d.irq_en = wdata[IRQ_EN_BIT];
            st_d.rst_en = wdata[RST_EN_BIT];
        end

        if (key_wr) st_d.armed = (wdata == UNLOCK_KEY);

        if (cmd_wr) begin
            st_d.armed = 1'b0;
            if (wdata[CMD_HALT_BIT] && st_q.armed) begin
                st_d.running = 1'b0;
                st_d.cnt     = '0;
                st_d.expn    = '0;
                st_d.irq     = 1'b0;
            end else if (wdata[CMD_GO_BIT]) begin
                st_d.running = 1'b1;
                st_d.cnt     = eff_period;
                st_d.expn    = '0;
                st_d.irq     = 1'b0;
            end
        end else if (st_q.running && tick) begin
            if (st_q.cnt > PER_W'(1)) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end else if (st_q.expn == EXP_LAST) begin
                if (st_q.rst_en) begin
                    st_d.rst     = 1'b1;
                    st_d.running = 1'b0;
                    st_d.cnt     = '0;
                    st_d.expn    = '0;
                    st_d.irq     = 1'b0;
                end else begin
                    st_d.cnt = eff_period;
                end
            end else begin
                st_d.cnt  = eff_period;
                st_d.expn = st_q.expn + 1'b1;
                if (st_q.irq_en) st_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_rd                       = '0;
        cfg_rd[SEL_W-1:0]            = st_q.sel;
        cfg_rd[PER_LSB +: PER_W]     = st_q.period;
        cfg_rd[IRQ_EN_BIT]           = st_q.irq_en;
        cfg_rd[RST_EN_BIT]           = st_q.rst_en;
        sts_rd                       = '0;
        sts_rd[PER_LSB +: PER_W]     = st_q.cnt;
        sts_rd[EXP_LSB +: EXP_W]     = st_q.expn;
    end

    assign irq     = st_q.irq;
    assign rst_req = st_q.rst;

    p_rst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst |=> !st_q.rst);

    p_rst_on_fourth_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst |-> $past(st_q.expn == EXP_LAST && st_q.rst_en && tick));

    p_rst_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst |-> !st_q.running);

    p_halt_keyed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.running) && !st_q.running && !st_q.rst) |-> $past(st_q.armed && cmd_wr));

    p_live_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.running |-> (st_q.cnt != '0));

    p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> $past(st_q.irq_en));
endmodule

// File: rtl/wdg_unit.sv
module wdg_unit
    import wdg_pkg::*;
#(
    parameter int                ADDR_W     = 5,
    parameter int                RELOAD_W   = 29,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_C45A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              sys_rst_req_o
);
    localparam int TMR_IN_W = RELOAD_W + 2;

    logic              cfg_wr, cmd_wr, key_wr, tmr_wr;
    logic              tick;
    logic [DATA_W-1:0] cfg_rd, sts_rd, tmr_rd;
    logic [TMR_IN_W-1:0] tmr_wdata;

    assign tmr_wdata = {wdata_i[TMR_EN_BIT], wdata_i[TMR_PER_BIT], wdata_i[RELOAD_W-1:0]};

    wdg_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en     (wr_en_i),
        .word_addr (addr_i[ADDR_W-1:2]),
        .cfg_rd    (cfg_rd),
        .sts_rd    (sts_rd),
        .tmr_rd    (tmr_rd),
        .cfg_wr    (cfg_wr),
        .cmd_wr    (cmd_wr),
        .key_wr    (key_wr),
        .tmr_wr    (tmr_wr),
        .rdata     (rdata_o)
    );

    wdg_tick_timer #(.RELOAD_W(RELOAD_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_tick_i),
        .wr        (tmr_wr),
        .wdata     (tmr_wdata),
        .tick      (tick),
        .rd        (tmr_rd)
    );

    wdg_countdown #(.UNLOCK_KEY(UNLOCK_KEY)) u_cd (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cfg_wr),
        .cmd_wr  (cmd_wr),
        .key_wr  (key_wr),
        .wdata   (wdata_i),
        .tick    (tick),
        .cfg_rd  (cfg_rd),
        .sts_rd  (sts_rd),
        .irq     (irq_o),
        .rst_req (sys_rst_req_o)
    );
endmodule

// File: tb/wdg_unit_test.sv
`timescale 1ns/1ps
module wdg_unit_test;
    localparam logic [4:0] A_CFG = 5'h00;
    localparam logic [4:0] A_STS = 5'h04;
    localparam logic [4:0] A_CMD = 5'h08;
    localparam logic [4:0] A_KEY = 5'h0C;
    localparam logic [4:0] A_TMR = 5'h10;

    // {period, ticks, expected countdown, expected tally}
    localparam logic [31:0] VEC [0:7] = '{
        32'h07_00_07_00, 32'h05_02_03_00, 32'h05_05_05_01, 32'h03_07_02_02,
        32'h01_03_01_03, 32'h00_01_01_01, 32'hFF_0A_F5_00, 32'h02_09_01_03
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, sys_rst;
    logic [31:0] rd, vec_w;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    wdg_unit uut (
        .clk (clk), .rst_n (rst_n), .ref_tick_i (ref_tick), .wr_en_i (wr_en),
        .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata), .irq_o (irq),
        .sys_rst_req_o (sys_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic ref_once();
        ref_tick = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [31:0] sts(input logic [7:0] c, input logic [1:0] e);
        return {18'b0, e, c, 4'b0};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(A_CFG, rd); check("R1 cfg", rd, 32'h0);
        bus_read(A_STS, rd); check("R1 sts", rd, 32'h0);
        bus_read(A_TMR, rd); check("R1 tmr", rd, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 rst", {31'b0, sys_rst}, 32'h0);
        ref_once();
        bus_read(A_STS, rd); check("R1 idle", rd, 32'h0);

        // R2 periodic, reload 0: one tick per reference pulse
        bus_write(A_TMR, 32'hC000_0000);
        bus_read(A_TMR, rd); check("R2 readback", rd, 32'hC000_0000);

        // R5 R6 R9 vector table
        for (int v = 0; v < 8; v++) begin
            vec_w = VEC[v];
            bus_write(A_CFG, {20'b0, vec_w[31:24], 4'b0});
            bus_write(A_CMD, 32'h1);
            for (int t = 0; t < int'(vec_w[23:16]); t++) ref_once();
            bus_read(A_STS, rd);
            check("R6 table", rd, sts(vec_w[15:8], vec_w[1:0]));
            check("R9 no reset", {31'b0, sys_rst}, 32'h0);
        end

        // R2 reload 2: tick every third pulse
        bus_write(A_TMR, 32'hC000_0002);
        bus_read(A_TMR, rd); check("R2 reload readback", rd, 32'hC000_0002);
        bus_write(A_CFG, 32'h0A0);
        bus_write(A_CMD, 32'h1);
        ref_once(); ref_once();
        bus_read(A_STS, rd); check("R2 two pulses", rd, sts(8'd10, 2'd0));
        ref_once();
        bus_read(A_STS, rd); check("R2 third pulse", rd, sts(8'd9, 2'd0));
        bus_write(A_TMR, 32'hC000_0000);

        // R11 R7 interrupt and keep-alive
        bus_write(A_CFG, 32'h1020);
        bus_write(A_CMD, 32'h1);
        ref_once();
        check("R11 before expiry", {31'b0, irq}, 32'h0);
        ref_once();
        check("R11 first expiry", {31'b0, irq}, 32'h1);
        ref_once(); ref_once();
        check("R11 held", {31'b0, irq}, 32'h1);
        bus_write(A_CMD, 32'h1);
        check("R7 irq cleared", {31'b0, irq}, 32'h0);
        bus_read(A_STS, rd); check("R7 reload", rd, sts(8'd2, 2'd0));
        bus_write(A_CFG, 32'h020);
        bus_write(A_CMD, 32'h1);
        ref_once(); ref_once();
        check("R11 disabled", {31'b0, irq}, 32'h0);

        // R10 guarded stop
        bus_write(A_CMD, 32'h1);
        bus_write(A_CMD, 32'h2);
        ref_once();
        bus_read(A_STS, rd); check("R10 no key", rd, sts(8'd1, 2'd0));
        bus_write(A_CMD, 32'h1);
        bus_write(A_KEY, 32'h0000_C45B);
        bus_write(A_CMD, 32'h2);
        ref_once();
        bus_read(A_STS, rd); check("R10 wrong key", rd, sts(8'd1, 2'd0));
        bus_write(A_CMD, 32'h1);
        bus_write(A_KEY, 32'h0000_C45A);
        bus_write(A_CMD, 32'h1);
        bus_write(A_CMD, 32'h2);
        ref_once();
        bus_read(A_STS, rd); check("R10 key consumed", rd, sts(8'd1, 2'd0));
        bus_write(A_CFG, 32'h1020);
        bus_write(A_CMD, 32'h1);
        ref_once(); ref_once();
        check("R11 set before stop", {31'b0, irq}, 32'h1);
        bus_write(A_KEY, 32'h0000_C45A);
        bus_write(A_CMD, 32'h2);
        bus_read(A_STS, rd); check("R10 stopped", rd, 32'h0);
        check("R11 stop clears", {31'b0, irq}, 32'h0);
        ref_once();
        bus_read(A_STS, rd); check("R10 stays stopped", rd, 32'h0);

        // R8 reset on fourth expiry
        bus_write(A_CFG, 32'h8020);
        bus_write(A_CMD, 32'h1);
        for (int t = 0; t < 7; t++) ref_once();
        bus_read(A_STS, rd); check("R8 before fourth", rd, sts(8'd1, 2'd3));
        check("R8 quiet", {31'b0, sys_rst}, 32'h0);
        ref_once();
        check("R8 pulse", {31'b0, sys_rst}, 32'h1);
        @(negedge clk);
        check("R8 one cycle", {31'b0, sys_rst}, 32'h0);
        bus_read(A_STS, rd); check("R8 idle", rd, 32'h0);
        ref_once();
        bus_read(A_STS, rd); check("R8 no count", rd, 32'h0);

        // R3 one-shot timer and stop by zero
        bus_write(A_CFG, 32'h0A0);
        bus_write(A_TMR, 32'h8000_0000);
        bus_write(A_CMD, 32'h1);
        ref_once();
        bus_read(A_STS, rd); check("R3 single tick", rd, sts(8'd9, 2'd0));
        bus_read(A_TMR, rd); check("R3 enable cleared", rd, 32'h0);
        ref_once();
        bus_read(A_STS, rd); check("R3 no second tick", rd, sts(8'd9, 2'd0));
        bus_write(A_TMR, 32'hC000_0000);
        ref_once();
        bus_read(A_STS, rd); check("R3 restarted", rd, sts(8'd8, 2'd0));
        bus_write(A_TMR, 32'h0);
        ref_once();
        bus_read(A_STS, rd); check("R3 zero stops", rd, sts(8'd8, 2'd0));

        // R4 config layout
        bus_write(A_CFG, 32'hFFFF_FFFF);
        bus_read(A_CFG, rd); check("R4 layout", rd, 32'h0000_9FFF);
        bus_write(A_CFG, 32'h0000_1235);
        bus_read(A_CFG, rd); check("R4 fields", rd, 32'h0000_1235);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule